// File: doc/BRIEF.md
# 1-Wire Network-Layer Monitor

A passive observer that sits above a 1-Wire link-layer receiver. It takes a stream of decoded events: single bits and reset/presence pulses. From them it follows the ROM-command phase of each bus transaction. The first eight bits after a reset form the ROM command. That byte decides what happens next: the 64-bit device address is gathered as a plain read, or it is gathered as a search, or the monitor goes straight to transport data. An unknown command sends it into an error phase.

Every result leaves the block as a record with a single-cycle valid strobe. The record types are:
- the reset record, with its presence flag;
- the command record, with its byte and a recognised flag;
- the address record;
- the transport data byte;
- the raw error byte.

During a search, three bit events make up each address position: first the true bit, then the complement bit, then the direction bit. The direction bits form the address. The true vector and the complement vector are also kept, so a consumer can find the positions where both are 0. Those are discrepancies.

Top module: `ow_net_monitor`

## Requirements
- R1: An event with kind 2'b10 (reset/presence), in any phase, raises `rst_rec_valid` in the same cycle with `rst_rec_presence` equal to `evt_val`. After it, the next 8 bits are decoded as a ROM command.
- R2: Fields are assembled least-significant bit first. The n-th bit of a field, counted from 0, lands at bit n of the reported value.
- R3: Command bytes 0x33, 0x0F, 0x55 and 0x69 are reported as recognised. The following 64 bits are reported as `rom_addr` with `rom_from_search`=0, and the monitor then enters the transport phase.
- R4: Command bytes 0xF0 and 0xEC are recognised and start a search of 64 triplets, taken in the order true, complement, direction. The address record carries the direction bits in `rom_addr`, the true bits in `rom_true` and the complement bits in `rom_comp`, with `rom_from_search`=1. The monitor then enters the transport phase.
- R5: Command bytes 0xCC, 0x3C and 0xA5 are recognised and go straight to the transport phase.
- R6: Any other command byte is reported with `cmd_known`=0. Every later group of 8 bits is then reported as an error byte until the next reset event.
- R7: In the transport phase, every 8 bits produce one data record. The phase lasts until a reset event, and no byte in it is taken as a command.
- R8: Events with `evt_valid`=0, or with kind 2'b00 or 2'b11, have no effect on any output or on the assembly of the current field.
- R9: Every record is a single-cycle pulse, issued in the cycle of the bit that completes its field. At most one record valid is high in any cycle.
- R10: A reset event in the middle of a field discards the partial bits, and collection restarts at bit 0 of a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event present this cycle |
| evt_kind | input | 2 | 2'b01 bit, 2'b10 reset/presence, others ignored |
| evt_val | input | 1 | Bit value, or presence flag for a reset event |
| rst_rec_valid | output | 1 | Reset record strobe |
| rst_rec_presence | output | 1 | Presence flag of the reset record |
| cmd_valid | output | 1 | Command record strobe |
| cmd_byte | output | 8 | ROM command byte |
| cmd_known | output | 1 | Command belongs to the recognised set |
| rom_valid | output | 1 | Address record strobe |
| rom_addr | output | 64 | Device address (read bits or direction bits) |
| rom_true | output | 64 | Search true-bit vector |
| rom_comp | output | 64 | Search complement-bit vector |
| rom_from_search | output | 1 | Address came from a search |
| data_valid | output | 1 | Transport data strobe |
| data_byte | output | 8 | Transport data byte |
| err_valid | output | 1 | Error byte strobe |
| err_byte | output | 8 | Raw byte after an unknown command |

## Verification
Every record is due in the cycle of the event that completes it: zero cycles after the final bit, or after the reset event. The strobe falls at the next clock edge. The bench drives each event at a falling edge and holds it for one cycle. A monitor samples a quarter period later, inside the same cycle, and compares each strobe it sees against the head of an expected-record queue that the driver filled before the completing bit. A record arriving early or late therefore shows up as a mismatch or as an unexpected record. The bench also checks at the end that no expected record is left in the queue.

// File: rtl/ow_net_monitor.sv
module ow_net_monitor #(
  parameter int ROM_BITS  = 64,
  parameter int BYTE_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_valid,
  input  logic [1:0]          evt_kind,
  input  logic                evt_val,
  output logic                rst_rec_valid,
  output logic                rst_rec_presence,
  output logic                cmd_valid,
  output logic [BYTE_BITS-1:0] cmd_byte,
  output logic                cmd_known,
  output logic                rom_valid,
  output logic [ROM_BITS-1:0] rom_addr,
  output logic [ROM_BITS-1:0] rom_true,
  output logic [ROM_BITS-1:0] rom_comp,
  output logic                rom_from_search,
  output logic                data_valid,
  output logic [BYTE_BITS-1:0] data_byte,
  output logic                err_valid,
  output logic [BYTE_BITS-1:0] err_byte
);
  localparam int CW = $clog2(ROM_BITS);
  localparam logic [1:0] EV_BIT = 2'b01;
  localparam logic [1:0] EV_RST = 2'b10;

  typedef enum logic [2:0] {PH_CMD, PH_READ, PH_SRCH, PH_XFER, PH_ERR} phase_t;

  phase_t              phase, cmd_next;
  logic [CW-1:0]       cnt;
  logic [1:0]          trip;
  logic [ROM_BITS-2:0] acc;
  logic [ROM_BITS-1:0] tru, cmp;

  wire is_bit    = evt_valid && evt_kind == EV_BIT;
  wire is_rst    = evt_valid && evt_kind == EV_RST;
  wire last_byte = cnt == CW'(BYTE_BITS - 1);
  wire last_rom  = cnt == CW'(ROM_BITS - 1);
  wire byte_end  = is_bit && last_byte;

  wire [BYTE_BITS-1:0] byte_now = {evt_val, acc[BYTE_BITS-2:0]};

  always_comb begin
    case (byte_now)
      8'h33, 8'h0F, 8'h55, 8'h69: cmd_next = PH_READ;
      8'hF0, 8'hEC:               cmd_next = PH_SRCH;
      8'hCC, 8'h3C, 8'hA5:        cmd_next = PH_XFER;
      default:                    cmd_next = PH_ERR;
    endcase
  end

  assign rst_rec_valid    = is_rst;
  assign rst_rec_presence = evt_val;

  assign cmd_valid  = byte_end && phase == PH_CMD;
  assign cmd_byte   = byte_now;
  assign cmd_known  = cmd_next != PH_ERR;

  assign data_valid = byte_end && phase == PH_XFER;
  assign data_byte  = byte_now;
  assign err_valid  = byte_end && phase == PH_ERR;
  assign err_byte   = byte_now;

  assign rom_valid       = is_bit && last_rom &&
                           (phase == PH_READ || (phase == PH_SRCH && trip == 2'd2));
  assign rom_addr        = {evt_val, acc};
  assign rom_true        = tru;
  assign rom_comp        = cmp;
  assign rom_from_search = phase == PH_SRCH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_CMD;
      cnt   <= '0;
      trip  <= '0;
      acc   <= '0;
      tru   <= '0;
      cmp   <= '0;
    end else if (is_rst) begin
      phase <= PH_CMD;
      cnt   <= '0;
      trip  <= '0;
    end else if (is_bit) begin
      case (phase)
        PH_SRCH: begin
          case (trip)
            2'd0: begin tru[cnt] <= evt_val; trip <= 2'd1; end
            2'd1: begin cmp[cnt] <= evt_val; trip <= 2'd2; end
            default: begin
              if (!last_rom) acc[cnt] <= evt_val;
              trip <= 2'd0;
              if (last_rom) begin
                cnt   <= '0;
                phase <= PH_XFER;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          endcase
        end
        PH_READ: begin
          if (!last_rom) acc[cnt] <= evt_val;
          if (last_rom) begin
            cnt   <= '0;
            phase <= PH_XFER;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (!last_byte) acc[cnt] <= evt_val;
          if (last_byte) begin
            cnt <= '0;
            if (phase == PH_CMD) phase <= cmd_next;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ow_net_monitor_chk.sv
module ow_net_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_valid,
  input logic       rst_rec_valid,
  input logic       cmd_valid,
  input logic       cmd_known,
  input logic       rom_valid,
  input logic       data_valid,
  input logic       err_valid
);
  AST_ONE_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_rec_valid, cmd_valid, rom_valid, data_valid, err_valid})); // R9

  AST_RST_NO_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_rec_valid |=> !(data_valid || err_valid || rom_valid || cmd_valid)); // R1

  AST_ROM_THEN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    rom_valid |=> !(rom_valid || cmd_valid || err_valid)); // R3

  AST_BAD_CMD_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_known) |=> !(data_valid || rom_valid || cmd_valid)); // R6

  AST_XFER_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !(cmd_valid || rom_valid || err_valid)); // R7

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> !(rst_rec_valid || cmd_valid || rom_valid || data_valid || err_valid)); // R8
endmodule

bind ow_net_monitor ow_net_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .rst_rec_valid(rst_rec_valid),
  .cmd_valid(cmd_valid), .cmd_known(cmd_known), .rom_valid(rom_valid),
  .data_valid(data_valid), .err_valid(err_valid)
);

// File: tb/ow_net_monitor_tb_top.sv
module ow_net_monitor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic [1:0] evt_kind = 2'b00;
  logic evt_val = 1'b0;
  logic rst_rec_valid, rst_rec_presence, cmd_valid, cmd_known;
  logic rom_valid, rom_from_search, data_valid, err_valid;
  logic [7:0] cmd_byte, data_byte, err_byte;
  logic [63:0] rom_addr, rom_true, rom_comp;

  always #(CLK_PERIOD/2) clk = ~clk;

  ow_net_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_val(evt_val),
    .rst_rec_valid(rst_rec_valid), .rst_rec_presence(rst_rec_presence),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_known(cmd_known),
    .rom_valid(rom_valid), .rom_addr(rom_addr), .rom_true(rom_true), .rom_comp(rom_comp),
    .rom_from_search(rom_from_search), .data_valid(data_valid), .data_byte(data_byte),
    .err_valid(err_valid), .err_byte(err_byte)
  );

  typedef struct {
    int          kind;  // 0 rst, 1 cmd, 2 rom, 3 data, 4 err
    logic [63:0] a;
    logic [63:0] t;
    logic [63:0] c;
    logic        f;
    string       req;
  } rec_t;

  rec_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic expect_rec(input int kind, input logic [63:0] a, input logic [63:0] t,
                            input logic [63:0] c, input logic f, input string req);
    rec_t r;
    r.kind = kind; r.a = a; r.t = t; r.c = c; r.f = f; r.req = req;
    exp_q.push_back(r);
  endtask

  task automatic compare(input rec_t g);
    rec_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected record kind=%0d a=%h (expected none) R9", g.kind, g.a);
      return;
    end
    e = exp_q.pop_front();
    if (g.kind != e.kind || g.a != e.a || g.f != e.f ||
        (e.kind == 2 && e.f && (g.t != e.t || g.c != e.c))) begin
      errors++;
      $display("FAIL %s: got kind=%0d a=%h t=%h c=%h f=%b, expected kind=%0d a=%h t=%h c=%h f=%b",
               e.req, g.kind, g.a, g.t, g.c, g.f, e.kind, e.a, e.t, e.c, e.f);
    end
  endtask

  always @(negedge clk) begin
    rec_t g;
    #(CLK_PERIOD/4);
    if (rst_n) begin
      g.t = '0; g.c = '0; g.f = 1'b0;
      if (rst_rec_valid) begin g.kind = 0; g.a = {63'd0, rst_rec_presence}; compare(g); end
      if (cmd_valid) begin g.kind = 1; g.a = {56'd0, cmd_byte}; g.f = cmd_known; compare(g); end
      if (rom_valid) begin
        g.kind = 2; g.a = rom_addr; g.t = rom_true; g.c = rom_comp; g.f = rom_from_search;
        compare(g);
      end
      if (data_valid) begin g.kind = 3; g.a = {56'd0, data_byte}; g.f = 1'b0; compare(g); end
      if (err_valid) begin g.kind = 4; g.a = {56'd0, err_byte}; g.f = 1'b0; compare(g); end
    end
  end

  task automatic send_evt(input logic [1:0] k, input logic v);
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = k; evt_val = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt_valid = 1'b0; evt_kind = 2'b00; evt_val = 1'b0;
    end
  endtask

  task automatic send_reset(input logic p, input string req);
    expect_rec(0, {63'd0, p}, '0, '0, 1'b0, req);
    send_evt(2'b10, p);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_evt(2'b01, b[i]);
  endtask

  task automatic cmd(input logic [7:0] b, input logic known, input string req);
    expect_rec(1, {56'd0, b}, '0, '0, known, req);
    send_byte(b);
  endtask

  task automatic data(input logic [7:0] b, input string req);
    expect_rec(3, {56'd0, b}, '0, '0, 1'b0, req);
    send_byte(b);
  endtask

  task automatic read_rom(input logic [63:0] a, input string req);
    expect_rec(2, a, '0, '0, 1'b0, req);
    for (int i = 0; i < 64; i++) send_evt(2'b01, a[i]);
  endtask

  task automatic search_rom(input logic [63:0] d, input logic [63:0] m, input string req);
    logic [63:0] t, c;
    t = d & ~m;
    c = ~d & ~m;
    expect_rec(2, d, t, c, 1'b1, req);
    for (int i = 0; i < 64; i++) begin
      send_evt(2'b01, t[i]);
      send_evt(2'b01, c[i]);
      send_evt(2'b01, d[i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired (R9 progress)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    @(negedge clk); #(CLK_PERIOD/4);
    checks++;
    if (rst_rec_valid || cmd_valid || rom_valid || data_valid || err_valid) begin
      errors++;
      $display("FAIL R1 reset state: valids=%b expected 00000",
               {rst_rec_valid, cmd_valid, rom_valid, data_valid, err_valid});
    end

    // R2 R5 R7: skip command, then data bytes LSB first
    send_reset(1'b1, "R1 presence 1");
    cmd(8'hCC, 1'b1, "R5 skip 0xCC");
    data(8'h5A, "R7 data 0x5A");
    data(8'h81, "R2 data 0x81 lsb first");
    data(8'h33, "R7 read code in transport is data");

    // R3 read commands
    send_reset(1'b0, "R1 presence 0");
    cmd(8'h33, 1'b1, "R3 read 0x33");
    read_rom(64'h0123_4567_89AB_CDEF, "R3 read address");
    data(8'hF0, "R7 data after rom");
    send_reset(1'b1, "R1");
    cmd(8'h0F, 1'b1, "R3 cond read 0x0F");
    read_rom(64'h8000_0000_0000_0001, "R2 address ends");
    send_reset(1'b1, "R1");
    cmd(8'h55, 1'b1, "R3 match 0x55");
    read_rom(64'hFEDC_BA98_7654_3210, "R3 match address");
    data(8'hA5, "R7 data after match");
    send_reset(1'b1, "R1");
    cmd(8'h69, 1'b1, "R3 od match 0x69");
    read_rom(64'h28FF_0011_2233_4455, "R3 od match address");

    // R5 other direct commands
    send_reset(1'b1, "R1");
    cmd(8'h3C, 1'b1, "R5 od skip 0x3C");
    data(8'h00, "R7 data 0x00");
    send_reset(1'b1, "R1");
    cmd(8'hA5, 1'b1, "R5 resume 0xA5");
    data(8'hFF, "R7 data 0xFF");

    // R4 search
    send_reset(1'b1, "R1");
    cmd(8'hF0, 1'b1, "R4 search 0xF0");
    search_rom(64'hA5C3_0F96_1E2D_3C4B, 64'h0000_1000_0040_0001, "R4 search triplets");
    data(8'h44, "R7 data after search");
    send_reset(1'b1, "R1");
    cmd(8'hEC, 1'b1, "R4 cond search 0xEC");
    search_rom(64'h1357_9BDF_0246_8ACE, 64'h8000_0000_0000_0000, "R4 cond search triplets");

    // R6 unknown command
    send_reset(1'b1, "R1");
    cmd(8'h12, 1'b0, "R6 unknown 0x12");
    expect_rec(4, 64'h77, '0, '0, 1'b0, "R6 error byte 0x77");
    send_byte(8'h77);
    expect_rec(4, 64'hCC, '0, '0, 1'b0, "R6 error byte 0xCC");
    send_byte(8'hCC);
    send_evt(2'b01, 1'b1);
    send_evt(2'b01, 1'b0);
    send_reset(1'b1, "R10 reset mid error byte");
    cmd(8'h00, 1'b0, "R6 unknown 0x00");

    // R10 reset mid command
    send_reset(1'b1, "R1");
    send_evt(2'b01, 1'b1);
    send_evt(2'b01, 1'b1);
    send_evt(2'b01, 1'b1);
    send_reset(1'b0, "R10 reset mid command");
    cmd(8'hCC, 1'b1, "R10 fresh command after reset");
    send_evt(2'b01, 1'b1);
    send_reset(1'b1, "R10 reset mid data");
    cmd(8'h55, 1'b1, "R10 command after data abort");

    // R8 ignored events interleaved with a byte
    send_reset(1'b1, "R1");
    cmd(8'hA5, 1'b1, "R5 resume for R8");
    expect_rec(3, 64'h96, '0, '0, 1'b0, "R8 byte unaffected by ignored events");
    for (int i = 0; i < 8; i++) begin
      send_evt(2'b01, i[0] ^ i[1] ^ i[2] ? 1'b1 : 1'b0);
      send_evt(2'b00, 1'b1);
      send_evt(2'b11, 1'b0);
      @(negedge clk);
      evt_valid = 1'b0; evt_kind = 2'b10; evt_val = 1'b1;
    end
    idle(5);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 records missing: got %0d left, expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule